// File: doc/BRIEF.md
# Complementary PWM Pair with Synchronized Output Swap

This block turns a shared up-counter into a pair of complementary PWM outputs for one channel pair. It compares the counter against an initial (period start) value and against two compare values, one per channel. The counter itself comes from outside. The start of the period, the first compare and the second compare each drive the primary output to a fixed level. The secondary output is always the complement of the primary.

A two-bit polarity field picks high-true or low-true active levels. An invert control exchanges the two outputs of the pair. Software writes the invert bit into a shadow register. The bit that actually steers the outputs copies the shadow only on a one-cycle synchronization pulse. The swap is honoured only when the surrounding mode bits select plain combined complementary operation: enhanced features on, combine on, complementary on, and quadrature, dual-edge capture and center-aligned counting all off.

Every output change is registered on the rising clock edge that samples the matching counter value. A synchronization pulse and a new mode setting take effect on that same edge.

Top module: `pair_pwm_inv`

## Requirements
- R1: While `rstN` is low, both outputs sit at the inactive level for the current polarity: 0 when `polSel[0]` is 0 and 1 when `polSel[0]` is 1. Reset also clears both the shadow and the active invert bits.
- R2: With high-true polarity and no effective inversion, the edge that samples `cntVal == initVal` drives `outN` to 0. The edge that samples `cntVal == cmpLo` drives it to 1, and the edge that samples `cntVal == cmpHi` drives it to 0. On any other count, `outN` holds its level.
- R3: With low-true polarity and no effective inversion, the same three events drive `outN` to 1, 0 and 1 respectively.
- R4: When inversion is effective, `outN` carries the level that `outN1` would have carried without inversion. With high-true polarity this means 1 at period start, 0 on the `cmpLo` match and 1 on the `cmpHi` match.
- R5: Inversion is effective only when the active invert bit is 1, `enhEn`, `combineOn` and `complOn` are all 1, and `quadOn`, `dualCapOn` and `centerOn` are all 0. If any of these conditions fails, the outputs follow R2 or R3.
- R6: A write (`invWrEn` = 1) updates only the shadow bit. On an edge where `syncPulse` is 0, the active invert bit, and therefore the outputs, are unchanged.
- R7: On an edge where `syncPulse` is 1, the active bit takes the shadow value. If `invWrEn` is also 1 on that edge, it takes `invWrData` instead.
- R8: When several events hit the same count, the `cmpHi` match beats the `cmpLo` match, which beats the period start. Equal compare values therefore produce a zero-width pulse.
- R9: From the first clock edge after reset is released, `outN1` is always the complement of `outN`.
- R10: Polarity is decoded from `polSel[0]` alone. The value 2'b10 is the nominal high-true code, and 2'b00 behaves the same way. Both 2'b01 and 2'b11 select low-true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cntVal | input | CNT_W | Current counter value |
| initVal | input | CNT_W | Counter value at period start |
| cmpLo | input | CNT_W | Channel n compare value |
| cmpHi | input | CNT_W | Channel n+1 compare value |
| polSel | input | 2 | Polarity field; bit 0 set selects low-true |
| enhEn | input | 1 | Enhanced feature enable |
| quadOn | input | 1 | Quadrature mode active |
| dualCapOn | input | 1 | Dual-edge capture active |
| combineOn | input | 1 | Combine mode active |
| complOn | input | 1 | Complementary mode active |
| centerOn | input | 1 | Center-aligned counting active |
| invWrEn | input | 1 | Write strobe for the shadow invert bit |
| invWrData | input | 1 | Value written to the shadow invert bit |
| syncPulse | input | 1 | One-cycle synchronization event |
| outN | output | 1 | Channel n output |
| outN1 | output | 1 | Channel n+1 output |

## Verification
The bench builds the block with `CNT_W` = 6. At that width the counter wraps from 63 back to a random initial value every few dozen cycles, so a run of a few thousand cycles covers many full periods. Those periods include compare values that land on the period start, on each other, and close to the wrap point. The random phase also toggles the mode gates, the polarity field, buffer writes and sync pulses. Around that phase, directed periods cover every single gate that blocks inversion, a write issued without sync, and a write issued together with sync.

// File: rtl/pair_pwm_pkg.sv
package pair_pwm_pkg;

  // Per-cycle strobes from control to datapath.
  typedef struct packed {
    logic evStart;  // counter sits at period start
    logic evLo;     // channel n compare hit
    logic evHi;     // channel n+1 compare hit
    logic invAct;   // active invert bit (registered)
    logic invEff;   // invert effective after this edge
  } pairStrb_t;

endpackage

// File: rtl/pair_pwm_ctrl.sv
module pair_pwm_ctrl
  import pair_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntVal,
  input  logic [CNT_W-1:0] initVal,
  input  logic [CNT_W-1:0] cmpLo,
  input  logic [CNT_W-1:0] cmpHi,
  input  logic             enhEn,
  input  logic             quadOn,
  input  logic             dualCapOn,
  input  logic             combineOn,
  input  logic             complOn,
  input  logic             centerOn,
  input  logic             invWrEn,
  input  logic             invWrData,
  input  logic             syncPulse,
  output pairStrb_t        strb
);

  localparam int NUM_EV = 3;

  logic [NUM_EV-1:0][CNT_W-1:0] evRef;
  logic [NUM_EV-1:0]            evHit;
  logic invBuf, invAct, invActNext, gateOk;

  assign evRef[0] = initVal;
  assign evRef[1] = cmpLo;
  assign evRef[2] = cmpHi;

  for (genvar i = 0; i < NUM_EV; i++) begin : g_cmp
    assign evHit[i] = (cntVal == evRef[i]);
  end

  // Inversion is only honoured in plain combined complementary operation.
  assign gateOk = enhEn & ~quadOn & ~dualCapOn & combineOn & complOn & ~centerOn;

  always_comb begin
    invActNext = invAct;
    if (syncPulse) invActNext = invWrEn ? invWrData : invBuf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      invBuf <= 1'b0;
      invAct <= 1'b0;
    end else begin
      if (invWrEn) invBuf <= invWrData;
      invAct <= invActNext;
    end
  end

  always_comb begin
    strb.evStart = evHit[0];
    strb.evLo    = evHit[1];
    strb.evHi    = evHit[2];
    strb.invAct  = invAct;
    strb.invEff  = invActNext & gateOk;
  end

endmodule

// File: rtl/pair_pwm_dp.sv
module pair_pwm_dp
  import pair_pwm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  pairStrb_t strb,
  input  logic      lowTrue,
  output logic      outN,
  output logic      outN1
);

  logic rawQ, rawNext, outNQ, running;

  // Base waveform (high-true, not inverted); later events win.
  always_comb begin
    rawNext = rawQ;
    if (strb.evHi)        rawNext = 1'b0;
    else if (strb.evLo)   rawNext = 1'b1;
    else if (strb.evStart) rawNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ    <= 1'b0;
      outNQ   <= 1'b0;
      running <= 1'b0;
    end else begin
      rawQ    <= rawNext;
      outNQ   <= rawNext ^ lowTrue ^ strb.invEff;
      running <= 1'b1;
    end
  end

  // Until the first edge after reset both pins idle at the inactive level.
  assign outN  = running ? outNQ  : lowTrue;
  assign outN1 = running ? ~outNQ : lowTrue;

endmodule

// File: rtl/pair_pwm_inv.sv
module pair_pwm_inv
  import pair_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntVal,
  input  logic [CNT_W-1:0] initVal,
  input  logic [CNT_W-1:0] cmpLo,
  input  logic [CNT_W-1:0] cmpHi,
  input  logic [1:0]       polSel,
  input  logic             enhEn,
  input  logic             quadOn,
  input  logic             dualCapOn,
  input  logic             combineOn,
  input  logic             complOn,
  input  logic             centerOn,
  input  logic             invWrEn,
  input  logic             invWrData,
  input  logic             syncPulse,
  output logic             outN,
  output logic             outN1
);

  pairStrb_t strb;
  logic lowTrue;
  logic unusedPolHi;

  assign lowTrue     = polSel[0];
  assign unusedPolHi = polSel[1];

  pair_pwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .initVal(initVal),
    .cmpLo(cmpLo), .cmpHi(cmpHi), .enhEn(enhEn), .quadOn(quadOn),
    .dualCapOn(dualCapOn), .combineOn(combineOn), .complOn(complOn),
    .centerOn(centerOn), .invWrEn(invWrEn), .invWrData(invWrData),
    .syncPulse(syncPulse), .strb(strb)
  );

  pair_pwm_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .lowTrue(lowTrue),
    .outN(outN), .outN1(outN1)
  );

endmodule

// File: rtl/pair_pwm_chk.sv
module pair_pwm_chk
  import pair_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] initVal,
  input logic [CNT_W-1:0] cmpLo,
  input logic [CNT_W-1:0] cmpHi,
  input logic [1:0]       polSel,
  input logic             invWrEn,
  input logic             invWrData,
  input logic             syncPulse,
  input pairStrb_t        strb,
  input logic             outN,
  input logic             outN1
);

  logic started;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) started <= 1'b0;
    else       started <= 1'b1;
  end

  // R1: inactive level on both pins while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      a_r1_reset_idle: assert (outN == polSel[0] && outN1 == polSel[0]);
    end
  end

  a_r9_complement: assert property (@(posedge clk) disable iff (!rstN)
    started |-> (outN1 == ~outN));

  a_r8_hi_wins: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal == cmpHi) |=> (outN == ($past(polSel[0]) ^ $past(strb.invEff))));

  a_r2_lo_sets: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal == cmpLo && cntVal != cmpHi && !polSel[0])
      |=> (outN == ~$past(strb.invEff)));

  a_r3_start_lowtrue: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal == initVal && cntVal != cmpLo && cntVal != cmpHi && polSel[0])
      |=> (outN == ~$past(strb.invEff)));

  a_r6_no_sync_hold: assert property (@(posedge clk) disable iff (!rstN)
    !syncPulse |=> $stable(strb.invAct));

  a_r7_sync_with_write: assert property (@(posedge clk) disable iff (!rstN)
    (syncPulse && invWrEn) |=> (strb.invAct == $past(invWrData)));

endmodule

bind pair_pwm_inv pair_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cntVal(cntVal), .initVal(initVal),
  .cmpLo(cmpLo), .cmpHi(cmpHi), .polSel(polSel), .invWrEn(invWrEn),
  .invWrData(invWrData), .syncPulse(syncPulse), .strb(strb),
  .outN(outN), .outN1(outN1)
);

// File: tb/pair_pwm_inv_bench.sv
module pair_pwm_inv_bench;

  localparam int W = 6;
  localparam logic [W-1:0] TOP = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] cntVal = '0, initVal = '0, cmpLo = 8, cmpHi = 20;
  logic [1:0] polSel = 2'b10;
  logic enhEn = 1, quadOn = 0, dualCapOn = 0, combineOn = 1, complOn = 1, centerOn = 0;
  logic invWrEn = 0, invWrData = 0, syncPulse = 0;
  logic outN, outN1;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic mRaw = 0, mBuf = 0, mAct = 0, mEff = 0, mOut = 0;

  always #2 clk = ~clk;  // 250 MHz

  pair_pwm_inv #(.CNT_W(W)) u_pair_pwm_inv (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .initVal(initVal),
    .cmpLo(cmpLo), .cmpHi(cmpHi), .polSel(polSel), .enhEn(enhEn),
    .quadOn(quadOn), .dualCapOn(dualCapOn), .combineOn(combineOn),
    .complOn(complOn), .centerOn(centerOn), .invWrEn(invWrEn),
    .invWrData(invWrData), .syncPulse(syncPulse), .outN(outN), .outN1(outN1)
  );

  function automatic logic gateFn();
    return enhEn & ~quadOn & ~dualCapOn & combineOn & complOn & ~centerOn;
  endfunction

  function automatic logic rawFn(logic prev);
    if (cntVal == cmpHi) return 1'b0;
    if (cntVal == cmpLo) return 1'b1;
    if (cntVal == initVal) return 1'b0;
    return prev;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: model the edge, then check at the falling edge
  task automatic stepChk(string tag);
    @(posedge clk);
    mRaw = rawFn(mRaw);
    if (syncPulse) mAct = invWrEn ? invWrData : mBuf;
    if (invWrEn) mBuf = invWrData;
    mEff = mAct & gateFn();
    mOut = mRaw ^ polSel[0] ^ mEff;
    @(negedge clk);
    if (tag == "") chk(mEff ? "R4" : (polSel[0] ? "R3" : "R2"), outN, mOut);
    else chk(tag, outN, mOut);
    chk("R9", outN1, ~mOut);
    cntVal = (cntVal == TOP) ? initVal : cntVal + 1'b1;
    invWrEn = 0;
    syncPulse = 0;
  endtask

  task automatic period(string tag);
    for (int i = 0; i <= int'(TOP); i++) stepChk(tag);
  endtask

  task automatic setInv(logic v);
    invWrEn = 1; invWrData = v; syncPulse = 1;
    stepChk("R7");
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: reset idle levels for both polarities
    @(negedge clk);
    polSel = 2'b10; #0.5; chk("R1", outN, 1'b0); chk("R1", outN1, 1'b0);
    polSel = 2'b01; #0.5; chk("R1", outN, 1'b1); chk("R1", outN1, 1'b1);
    polSel = 2'b10;
    @(negedge clk);
    rstN = 1;
    initVal = 3; cntVal = 3; cmpLo = 10; cmpHi = 30;

    period("R2");
    polSel = 2'b01; period("R3");
    polSel = 2'b10; setInv(1'b1); period("R4");

    // R5: each blocking gate alone disables the swap
    enhEn = 0;     period("R5"); enhEn = 1;
    quadOn = 1;    period("R5"); quadOn = 0;
    dualCapOn = 1; period("R5"); dualCapOn = 0;
    combineOn = 0; period("R5"); combineOn = 1;
    complOn = 0;   period("R5"); complOn = 1;
    centerOn = 1;  period("R5"); centerOn = 0;

    // R6: write without sync leaves outputs on the inverted waveform
    invWrEn = 1; invWrData = 0; stepChk("R6");
    period("R6");
    syncPulse = 1; stepChk("R6");  // shadow 0 now transferred
    period("R6");

    // R7: simultaneous write and sync transfers the new value
    invWrEn = 1; invWrData = 1; stepChk("R7");   // shadow 1, no sync
    setInv(1'b0); period("R7");

    // R8: equal compares and compare on period start
    cmpLo = 12; cmpHi = 12; period("R8");
    cmpLo = initVal; cmpHi = 40; period("R8");
    cmpLo = 25; cmpHi = initVal; period("R8");

    // R10: other polarity codes
    cmpLo = 10; cmpHi = 30;
    polSel = 2'b00; period("R10");
    polSel = 2'b11; period("R10");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 60) == 0) begin
        initVal = W'($urandom_range(0, 20));
        cmpLo = W'($urandom_range(0, int'(TOP)));
        cmpHi = W'($urandom_range(0, int'(TOP)));
        polSel = 2'($urandom_range(0, 3));
      end
      if ($urandom_range(0, 40) == 0) begin
        enhEn = ($urandom_range(0, 5) != 0); quadOn = ($urandom_range(0, 5) == 0);
        dualCapOn = ($urandom_range(0, 5) == 0); combineOn = ($urandom_range(0, 5) != 0);
        complOn = ($urandom_range(0, 5) != 0); centerOn = ($urandom_range(0, 5) == 0);
      end
      invWrEn = ($urandom_range(0, 15) == 0);
      invWrData = 1'($urandom_range(0, 1));
      syncPulse = ($urandom_range(0, 20) == 0);
      stepChk("");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule